// File: doc/BRIEF.md
# Configurable Timer Counter Channel

This block is one channel of a general-purpose timer. A counter of parameterized width (16 bits by default) advances on a count source picked by a configuration word. The source is a tap of a free-running system-clock prescaler, one of several external clock pins with a selectable active edge, or a pair of up/down step pulses from a phase-counting decoder outside the block. While phase-counting mode is on, the clock-select field and the edge field have no effect.

Two general registers, A and B, can each be loaded from a shared write-data bus. Each works either as a compare register, which flags a match while the counter equals it, or as a capture register, which latches the counter on a rising edge of its own capture pin. The counter can be cleared by an event on A, by an event on B, or by a clear pulse that sibling channels broadcast to each other. A channel that clears through A or B drives that pulse out, so a group of channels can restart together.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, both general registers read all ones, the overflow flag is 0, and the configuration word is 0. That setting means: divide by 1, rising edge, no clear source, both registers in compare mode, phase counting off, and no sync membership.
- R2: Clock-select codes 000, 001, 010 and 011 count once every 1, 2, 4 and 8 system clocks, taken from a prescaler that runs freely from reset. The edge field has no effect on these codes.
- R3: Clock-select codes 100 to 111 select external pins 0 to 3. Each pin passes through a two-flop synchronizer. Edge field 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. Each edge is counted once.
- R4: When the phase flag is set, clock-select and edge are ignored. A phase_up pulse adds 1, a phase_dn pulse subtracts 1, and both together leave the counter unchanged.
- R5: Clear-select 00 never clears the counter.
- R6: Clear-select 01 clears on a register A event and 10 clears on a register B event. The event is a compare match in compare mode and a capture in capture mode. On the next clock edge the counter reads 0, even if a count was due in the same cycle.
- R7: Clear-select 11 clears the counter on the clock after sync_clr_in is high, but only when the sync-join bit is set. Otherwise sync_clr_in is ignored.
- R8: sync_clr_out is high in exactly the cycles in which a register A or B clear is taken. It stays low under clear-select 00 and 11.
- R9: match_a and match_b are high while the counter equals the register and that register is in compare mode. They are low in capture mode.
- R10: In capture mode, a rising edge on the synchronized capture pin copies the counter into the register on the next clock edge.
- R11: An up-count from all ones wraps to 0 and raises overflow for exactly that one cycle.
- R12: The configuration word is laid out as follows: bits [2:0] clock-select, [4:3] edge, [6:5] clear-select, [7] A capture mode, [8] B capture mode, [9] phase flag, [10] sync-join. It loads on cfg_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration word |
| cfg_wdata | input | 11 | Configuration word (layout in R12) |
| gr_a_we | input | 1 | Load register A from gr_wdata |
| gr_b_we | input | 1 | Load register B from gr_wdata |
| gr_wdata | input | CNT_W | General register write data |
| ext_clk | input | EXT_PINS | External clock pins |
| cap_pin_a | input | 1 | Capture pin of register A |
| cap_pin_b | input | 1 | Capture pin of register B |
| phase_up | input | 1 | Phase-counting up step |
| phase_dn | input | 1 | Phase-counting down step |
| sync_clr_in | input | 1 | OR of sibling clear pulses |
| count | output | CNT_W | Counter value |
| gr_a | output | CNT_W | Register A value |
| gr_b | output | CNT_W | Register B value |
| match_a | output | 1 | Register A compare match |
| match_b | output | 1 | Register B compare match |
| overflow | output | 1 | One-cycle wrap flag |
| sync_clr_out | output | 1 | This channel clears through A or B |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- a taken A/B clear or sync clear leaves the counter at 0 next cycle;
- with no clear source, the counter only holds or steps by one;
- overflow follows only a wrap from all ones;
- matches are silent in capture mode;
- the sync output is silent under the none and sync clear codes.

Only the bench's scenarios can show how often the counter advances for each prescaler tap and external edge choice, and that deselected pins and the overridden fields have no effect. The same holds for the exact value latched on a capture and for where the counter lands after several clear periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      CLR_NONE = 2'b00,
      CLR_A    = 2'b01,
      CLR_B    = 2'b10,
      CLR_SYNC = 2'b11
   } clr_sel_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_BOTH = 2'b10,
      EDGE_BTH2 = 2'b11
   } edge_sel_e;

   // packed MSB first: sync_join is bit 10, clk_sel is bits [2:0]
   typedef struct packed {
      logic      sync_join;
      logic      phase;
      logic      cap_b;
      logic      cap_a;
      clr_sel_e  clr_sel;
      edge_sel_e edge_sel;
      logic [2:0] clk_sel;
   } cfg_t;

   localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [STAGES:0]   taps
);

   logic [STAGES-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   // tap k pulses once per 2**k clocks (on the cycle before bit k-1 falls)
   assign taps[0] = 1'b1;
   for (genvar k = 1; k <= STAGES; k++) begin : g_tap
      assign taps[k] = &div_q[k-1:0];
   end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);

   logic [W-1:0] meta_q, sync_q, hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         meta_q <= pin;
         sync_q <= meta_q;
         hist_q <= sync_q;
      end
   end

   assign cur  = sync_q;
   assign prev = hist_q;

endmodule

// File: rtl/tmr_gen_reg.sv
module tmr_gen_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             cap_mode,
   input  logic             cap_edge,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] value,
   output logic             match,
   output logic             evt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    value <= '1;
      else if (we)                   value <= wdata;
      else if (cap_mode && cap_edge) value <= count;
   end

   assign match = !cap_mode && (count == value);
   assign evt   = cap_mode ? cap_edge : match;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int PRESC_STAGES = 3,
   parameter int EXT_PINS     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [10:0]         cfg_wdata,
   input  logic                gr_a_we,
   input  logic                gr_b_we,
   input  logic [CNT_W-1:0]    gr_wdata,
   input  logic [EXT_PINS-1:0] ext_clk,
   input  logic                cap_pin_a,
   input  logic                cap_pin_b,
   input  logic                phase_up,
   input  logic                phase_dn,
   input  logic                sync_clr_in,
   output logic [CNT_W-1:0]    count,
   output logic [CNT_W-1:0]    gr_a,
   output logic [CNT_W-1:0]    gr_b,
   output logic                match_a,
   output logic                match_b,
   output logic                overflow,
   output logic                sync_clr_out
);

   localparam int NUM_TAPS = PRESC_STAGES + 1;
   localparam int SEL_SLOTS = 4;   // codes per half of the clock-select field

   if (CNT_W < 2 || CNT_W > 32)
      $error("tmr_channel: CNT_W must be 2..32");
   if (PRESC_STAGES < 1 || PRESC_STAGES > 3)
      $error("tmr_channel: PRESC_STAGES must be 1..3");
   if (EXT_PINS < 1 || EXT_PINS > SEL_SLOTS)
      $error("tmr_channel: EXT_PINS must be 1..4");
   if (CFG_W != 11)
      $error("tmr_channel: configuration word must be 11 bits");

   // ---------------- configuration register (R12) ----------------
   cfg_t cfg_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
   end

   logic [1:0] clr_sel_w;
   logic       cap_a_w, phase_w, sync_join_w;
   assign clr_sel_w   = cfg_q.clr_sel;
   assign cap_a_w     = cfg_q.cap_a;
   assign phase_w     = cfg_q.phase;
   assign sync_join_w = cfg_q.sync_join;

   // ---------------- internal prescaler taps ----------------
   logic [PRESC_STAGES:0] taps;
   logic [SEL_SLOTS-1:0]  tap_slot;

   tmr_prescaler #(.STAGES(PRESC_STAGES)) i_presc (
      .clk(clk), .rst_n(rst_n), .taps(taps)
   );

   for (genvar i = 0; i < SEL_SLOTS; i++) begin : g_tap_slot
      if (i < NUM_TAPS) begin : g_used
         assign tap_slot[i] = taps[i];
      end else begin : g_unused
         assign tap_slot[i] = 1'b0;
      end
   end

   // ---------------- external pins and capture pins ----------------
   logic [EXT_PINS+1:0] pin_cur, pin_prev;
   logic [SEL_SLOTS-1:0] ext_rise, ext_fall;
   logic [1:0]           cap_rise;

   tmr_edge_sync #(.W(EXT_PINS + 2)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .pin({cap_pin_b, cap_pin_a, ext_clk}),
      .cur(pin_cur), .prev(pin_prev)
   );

   for (genvar i = 0; i < SEL_SLOTS; i++) begin : g_ext_slot
      if (i < EXT_PINS) begin : g_used
         assign ext_rise[i] =  pin_cur[i] & ~pin_prev[i];
         assign ext_fall[i] = ~pin_cur[i] &  pin_prev[i];
      end else begin : g_unused
         assign ext_rise[i] = 1'b0;
         assign ext_fall[i] = 1'b0;
      end
   end
   assign cap_rise = pin_cur[EXT_PINS+1:EXT_PINS] & ~pin_prev[EXT_PINS+1:EXT_PINS];

   // ---------------- count source selection ----------------
   logic int_tick, ext_tick, step_up, step_dn;

   always_comb begin
      int_tick = tap_slot[cfg_q.clk_sel[1:0]];
      unique case (cfg_q.edge_sel)
         EDGE_RISE: ext_tick = ext_rise[cfg_q.clk_sel[1:0]];
         EDGE_FALL: ext_tick = ext_fall[cfg_q.clk_sel[1:0]];
         default:   ext_tick = ext_rise[cfg_q.clk_sel[1:0]] | ext_fall[cfg_q.clk_sel[1:0]];
      endcase
      if (phase_w) begin
         step_up = phase_up & ~phase_dn;
         step_dn = phase_dn & ~phase_up;
      end else begin
         step_up = cfg_q.clk_sel[2] ? ext_tick : int_tick;
         step_dn = 1'b0;
      end
   end

   // ---------------- general registers A and B ----------------
   logic [1:0]       gr_we, gr_cap, gr_match, gr_evt;
   logic [CNT_W-1:0] gr_val [2];

   assign gr_we  = {gr_b_we, gr_a_we};
   assign gr_cap = {cfg_q.cap_b, cap_a_w};

   for (genvar g = 0; g < 2; g++) begin : g_gr
      tmr_gen_reg #(.CNT_W(CNT_W)) i_gr (
         .clk(clk), .rst_n(rst_n),
         .we(gr_we[g]), .wdata(gr_wdata),
         .cap_mode(gr_cap[g]), .cap_edge(cap_rise[g]),
         .count(count),
         .value(gr_val[g]), .match(gr_match[g]), .evt(gr_evt[g])
      );
   end

   assign gr_a    = gr_val[0];
   assign gr_b    = gr_val[1];
   assign match_a = gr_match[0];
   assign match_b = gr_match[1];

   // ---------------- clear logic ----------------
   logic own_clr, clr;
   always_comb begin
      own_clr = (clr_sel_w == CLR_A && gr_evt[0]) ||
                (clr_sel_w == CLR_B && gr_evt[1]);
      clr     = own_clr ||
                (clr_sel_w == CLR_SYNC && sync_join_w && sync_clr_in);
   end
   assign sync_clr_out = own_clr;

   // ---------------- counter ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         overflow <= 1'b0;
         if (clr) begin
            count <= '0;
         end else if (step_up) begin
            count    <= count + 1'b1;
            overflow <= &count;
         end else if (step_dn) begin
            count <= count - 1'b1;
         end
      end
   end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             overflow,
   input logic             match_a,
   input logic             match_b,
   input logic             sync_clr_out,
   input logic             sync_clr_in,
   input logic             phase_up,
   input logic             phase_dn,
   input logic [1:0]       clr_sel,
   input logic             cap_a,
   input logic             phase_mode,
   input logic             sync_join
);

   assert_clear_on_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel == 2'b01 && match_a) |=> (count == '0));

   assert_clear_on_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel == 2'b10 && match_b) |=> (count == '0));

   assert_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel == 2'b00 && !phase_mode) |=>
         (count == $past(count) || count == $past(count) + 1'b1));

   assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel == 2'b11 && sync_join && sync_clr_in) |=> (count == '0));

   assert_sync_out_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_clr_out |=> (count == '0));

   assert_sync_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sel == 2'b00 || clr_sel == 2'b11) |-> !sync_clr_out);

   assert_no_match_in_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_a |-> !match_a);

   assert_overflow_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (count == '0 && $past(count) == {CNT_W{1'b1}}));

   assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_mode && clr_sel == 2'b00 && phase_up == phase_dn) |=> $stable(count));

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .count(count), .overflow(overflow),
   .match_a(match_a), .match_b(match_b), .sync_clr_out(sync_clr_out),
   .sync_clr_in(sync_clr_in), .phase_up(phase_up), .phase_dn(phase_dn),
   .clr_sel(clr_sel_w), .cap_a(cap_a_w), .phase_mode(phase_w),
   .sync_join(sync_join_w)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;

   localparam int CNT_W = 16;
   localparam int EXT_PINS = 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_we = 1'b0;
   logic [10:0]         cfg_wdata = '0;
   logic                gr_a_we = 1'b0, gr_b_we = 1'b0;
   logic [CNT_W-1:0]    gr_wdata = '0;
   logic [EXT_PINS-1:0] ext_clk = '0;
   logic                cap_pin_a = 1'b0, cap_pin_b = 1'b0;
   logic                phase_up = 1'b0, phase_dn = 1'b0;
   logic                sync_clr_in = 1'b0;
   logic [CNT_W-1:0]    count, gr_a, gr_b;
   logic                match_a, match_b, overflow, sync_clr_out;

   always #2.5 clk = ~clk;

   tmr_channel #(.CNT_W(CNT_W), .PRESC_STAGES(3), .EXT_PINS(EXT_PINS)) i_tmr_channel (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .gr_a_we(gr_a_we), .gr_b_we(gr_b_we), .gr_wdata(gr_wdata),
      .ext_clk(ext_clk), .cap_pin_a(cap_pin_a), .cap_pin_b(cap_pin_b),
      .phase_up(phase_up), .phase_dn(phase_dn), .sync_clr_in(sync_clr_in),
      .count(count), .gr_a(gr_a), .gr_b(gr_b), .match_a(match_a),
      .match_b(match_b), .overflow(overflow), .sync_clr_out(sync_clr_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // {cfg, gr_a, gr_b, expected count}; 16 edges after the config write.
   // The count is 3 when the new config takes effect.
   localparam logic [63:0] VEC [0:10] = '{
      {16'h0000, 16'h0005, 16'hFFFF, 16'd19},  // R2 div1, R5 no clear despite match
      {16'h0001, 16'hFFFF, 16'hFFFF, 16'd11},  // R2 div2
      {16'h0002, 16'hFFFF, 16'hFFFF, 16'd7 },  // R2 div4
      {16'h0003, 16'hFFFF, 16'hFFFF, 16'd5 },  // R2 div8
      {16'h0008, 16'hFFFF, 16'hFFFF, 16'd19},  // R2 edge=fall ignored on internal
      {16'h0011, 16'hFFFF, 16'hFFFF, 16'd11},  // R2 edge=both ignored on div2
      {16'h0020, 16'h0005, 16'hFFFF, 16'd1 },  // R6 clear on A match, period 6
      {16'h0040, 16'h0005, 16'h0003, 16'd3 },  // R6 clear on B match, period 4
      {16'h00A0, 16'h0005, 16'hFFFF, 16'd19},  // R9 capture mode: no match clear
      {16'h0200, 16'hFFFF, 16'hFFFF, 16'd3 },  // R4 phase mode overrides div1
      {16'h0004, 16'hFFFF, 16'hFFFF, 16'd3 }   // R3 external pin 0, idle
   };

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reset, load A, load B, load config (R12); leaves count == 3
   task automatic setup(logic [15:0] cfg, logic [15:0] ga, logic [15:0] gb);
      @(negedge clk);
      rst_n = 1'b0; ext_clk = '0; cap_pin_a = 0; cap_pin_b = 0;
      phase_up = 0; phase_dn = 0; sync_clr_in = 0;
      step(2);
      rst_n = 1'b1; gr_a_we = 1'b1; gr_wdata = ga;
      step(1);
      gr_a_we = 1'b0; gr_b_we = 1'b1; gr_wdata = gb;
      step(1);
      gr_b_we = 1'b0; cfg_we = 1'b1; cfg_wdata = cfg[10:0];
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_pin(int idx, int n);
      for (int p = 0; p < n; p++) begin
         ext_clk[idx] = 1'b1; step(3);
         ext_clk[idx] = 1'b0; step(3);
      end
      step(4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] c0;
      // R1 reset state
      step(2);
      check("R1 count", count, 0);
      check("R1 gr_a", gr_a, 16'hFFFF);
      check("R1 gr_b", gr_b, 16'hFFFF);
      check("R1 overflow", overflow, 0);
      check("R1 sync_out", sync_clr_out, 0);

      // vector table
      for (int v = 0; v < 11; v++) begin
         setup(VEC[v][63:48], VEC[v][47:32], VEC[v][31:16]);
         step(16);
         check($sformatf("R12 vector %0d count", v), count, VEC[v][15:0]);
      end

      // R3 external edge selections
      setup(16'h0004, 16'hFFFF, 16'hFFFF);
      c0 = count; pulse_pin(0, 2);
      check("R3 rising pin0", count, c0 + 2);
      setup(16'h000C, 16'hFFFF, 16'hFFFF);
      c0 = count; pulse_pin(0, 2);
      check("R3 falling pin0", count, c0 + 2);
      setup(16'h0014, 16'hFFFF, 16'hFFFF);
      c0 = count; pulse_pin(0, 2);
      check("R3 both edges pin0", count, c0 + 4);
      setup(16'h0005, 16'hFFFF, 16'hFFFF);
      c0 = count; pulse_pin(0, 2);
      check("R3 deselected pin0", count, c0);
      pulse_pin(1, 3);
      check("R3 selected pin1", count, c0 + 3);

      // R4 phase mode overrides the external selection
      setup(16'h0204, 16'hFFFF, 16'hFFFF);
      c0 = count; pulse_pin(0, 2);
      check("R4 ext ignored", count, c0);
      phase_up = 1'b1; step(3); phase_up = 1'b0; step(1);
      check("R4 up steps", count, c0 + 3);
      phase_dn = 1'b1; step(1); phase_dn = 1'b0; step(1);
      check("R4 down step", count, c0 + 2);
      phase_up = 1'b1; phase_dn = 1'b1; step(1); phase_up = 0; phase_dn = 0; step(1);
      check("R4 both steps", count, c0 + 2);

      // R9 / R8 / R6 compare match on A clears
      setup(16'h0020, 16'h0005, 16'hFFFF);
      step(2);
      check("R9 match_a at 5", match_a, 1);
      check("R8 sync_out on A clear", sync_clr_out, 1);
      step(1);
      check("R6 clear after match", count, 0);
      check("R9 no match at 0", match_a, 0);

      // R10 capture on A with clear on A
      setup(16'h00A0, 16'hFFFF, 16'hFFFF);
      step(4);
      cap_pin_a = 1'b1;
      step(2);
      c0 = count;
      check("R8 sync_out on capture", sync_clr_out, 1);
      step(1);
      check("R10 captured value", gr_a, c0);
      check("R6 clear on capture", count, 0);
      step(1);
      check("R10 one capture per edge", count, 1);
      cap_pin_a = 1'b0;

      // R7 sync clear
      setup(16'h0460, 16'hFFFF, 16'hFFFF);
      sync_clr_in = 1'b1;
      check("R8 sync_out quiet in sync mode", sync_clr_out, 0);
      step(1); sync_clr_in = 1'b0;
      check("R7 sync clear taken", count, 0);
      setup(16'h0060, 16'hFFFF, 16'hFFFF);
      sync_clr_in = 1'b1; step(1); sync_clr_in = 1'b0;
      check("R7 sync clear ignored without join", count, 4);

      // R11 overflow
      setup(16'h0000, 16'hFFFF, 16'hFFFF);
      for (int k = 0; k < 70000 && count != 16'hFFFE; k++) step(1);
      step(1);
      check("R11 at max", count, 16'hFFFF);
      check("R11 no flag before wrap", overflow, 0);
      step(1);
      check("R11 wrap to zero", count, 0);
      check("R11 flag on wrap", overflow, 1);
      step(1);
      check("R11 flag one cycle", overflow, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule